// File: doc/BRIEF.md
# Cartridge ROM Address Mapper

This block sits between a 24-bit console CPU address bus and a cartridge mask ROM. Each cycle it decodes the CPU address against the ROM window of the selected mapping mode. It then builds a ROM address in which some CPU lines are dropped, because the mode treats them as flags and not as address bits, and the higher lines move down to fill the gap. It also drives active-low chip-enable and output-enable strobes for the ROM.

A static two-bit mode input selects one of three maps. The low-half bank map places ROM in the upper 32 KiB of each bank. The linear high map places ROM in whole 64 KiB banks. The extended low-half map covers almost the full bank range and uses CPU bit 22 as an ordinary address bit. A size parameter clears the ROM address bits above the fitted ROM, so a small ROM repeats across the mapped space. All outputs are registered, one clock after the inputs.

Top module: `rom_addr_mapper`

## Requirements
- R1: Every output is registered and reflects the inputs sampled at the previous rising clock edge. While reset is high and in the first cycle after it, rom_ce_n=1, rom_oe_n=1 and rom_addr=0.
- R2: In mode 0 (low-half map), the ROM address is {0, A23, A21..A16, A14..A0} from bit 22 down to bit 0. CPU bit 15 is never a ROM bit.
- R3: In mode 0, the window is banks 00h–7Fh (A23=0) with A15=1. A22 does not change the ROM address.
- R4: In mode 1 (linear high map), the ROM address is {A23, A21..A0}. The window is banks 40h–7Dh and 80h–FFh, and banks 7Eh/7Fh never select the ROM.
- R5: In mode 1, bank 00h offsets FFE0h–FFFFh (the exception vectors) are also in the window and are mapped with the same formula. Offset FFDFh of bank 00h is not in the window.
- R6: In mode 2 (extended low-half map), the ROM address is {A23, A22..A16, A14..A0}. The window is A15=1 in any bank except 7Eh/7Fh.
- R7: With romsel_n=1, rom_ce_n stays 1 whatever the address.
- R8: rom_oe_n is low exactly when rom_ce_n is low and rd_n was low. When rd_n is high and the address is in the window, rom_ce_n=0 and rom_oe_n=1.
- R9: ROM address bits at or above ROM_LOG2 are always 0, so addresses that differ only in those bits map to the same ROM location.
- R10: Mode 3 is disabled, and rom_ce_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_mode | input | 2 | 0 low-half, 1 linear high, 2 extended low-half, 3 off |
| cpu_addr | input | 24 | CPU address, bank in bits 23..16 |
| romsel_n | input | 1 | Active-low ROM-area select strobe |
| rd_n | input | 1 | Active-low read strobe |
| rom_addr | output | 23 | Mapped ROM address |
| rom_ce_n | output | 1 | Active-low ROM chip enable |
| rom_oe_n | output | 1 | Active-low ROM output enable |

## Verification
On every cycle, the assertions check several rules. Output enable never asserts without chip enable. A high select strobe, mode 3, the work-RAM banks in the high map and A15 low in the low-half map all keep the ROM idle. No address bit above the fitted size is ever set, and the low fifteen lines pass straight through in the low-half map. The full bit permutation of each mode, the vector window edges, the A22 independence of the low-half map and the mirroring between specific banks are shown only by the bench's directed and random scenarios. The bench compares those scenarios against its own model of the maps.

// File: rtl/rom_map_pkg.sv
package rom_map_pkg;
  localparam int CPU_AW = 24;
  localparam int ROM_AW = CPU_AW - 1;
  localparam int BANK_W = 8;

  typedef enum logic [1:0] {
    MAP_LO   = 2'd0,
    MAP_HI   = 2'd1,
    MAP_EXLO = 2'd2,
    MAP_OFF  = 2'd3
  } map_mode_e;
endpackage

// File: rtl/rom_map_window.sv
module rom_map_window
  import rom_map_pkg::*;
#(
  parameter logic [15:0] VEC_LO = 16'hFFE0
) (
  input  logic [CPU_AW-1:0] addr,
  input  map_mode_e         mode,
  output logic              hit
);
  logic [BANK_W-1:0] bank;
  logic              wram_bank;
  logic              vec_fetch;
  logic              lo_hit, hi_hit, ex_hit;

  assign bank      = addr[CPU_AW-1 -: BANK_W];
  assign wram_bank = (bank == 8'h7E) || (bank == 8'h7F);
  assign vec_fetch = (bank == 8'h00) && (addr[15:0] >= VEC_LO);

  assign lo_hit = !addr[23] && addr[15];
  assign hi_hit = addr[23] || (addr[22] && !wram_bank) || vec_fetch;
  assign ex_hit = addr[15] && !wram_bank;

  always_comb begin
    unique case (mode)
      MAP_LO:   hit = lo_hit;
      MAP_HI:   hit = hi_hit;
      MAP_EXLO: hit = ex_hit;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/rom_map_permute.sv
module rom_map_permute
  import rom_map_pkg::*;
(
  input  logic [CPU_AW-1:0] addr,
  input  map_mode_e         mode,
  output logic [ROM_AW-1:0] raw
);
  logic [ROM_AW-1:0] lo_map, hi_map, ex_map;

  assign lo_map = {1'b0, addr[23], addr[21:16], addr[14:0]};
  assign hi_map = {addr[23], addr[21:0]};
  assign ex_map = {addr[23], addr[22:16], addr[14:0]};

  always_comb begin
    unique case (mode)
      MAP_LO:   raw = lo_map;
      MAP_HI:   raw = hi_map;
      MAP_EXLO: raw = ex_map;
      default:  raw = '0;
    endcase
  end
endmodule

// File: rtl/rom_map_mirror.sv
module rom_map_mirror
  import rom_map_pkg::*;
#(
  parameter int ROM_LOG2 = 21
) (
  input  logic [ROM_AW-1:0] raw,
  output logic [ROM_AW-1:0] fitted
);
  for (genvar i = 0; i < ROM_AW; i++) begin : g_bit
    if (i < ROM_LOG2) begin : g_keep
      assign fitted[i] = raw[i];
    end else begin : g_drop
      assign fitted[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rom_addr_mapper.sv
module rom_addr_mapper
  import rom_map_pkg::*;
#(
  parameter int          ROM_LOG2 = 21,
  parameter logic [15:0] VEC_LO   = 16'hFFE0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        map_mode,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              romsel_n,
  input  logic              rd_n,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_ce_n,
  output logic              rom_oe_n
);
  map_mode_e         mode;
  logic              hit;
  logic              ce_d, oe_d;
  logic [ROM_AW-1:0] raw, fitted;

  assign mode = map_mode_e'(map_mode);

  rom_map_window #(.VEC_LO(VEC_LO)) u_window (
    .addr (cpu_addr),
    .mode (mode),
    .hit  (hit)
  );

  rom_map_permute u_permute (
    .addr (cpu_addr),
    .mode (mode),
    .raw  (raw)
  );

  rom_map_mirror #(.ROM_LOG2(ROM_LOG2)) u_mirror (
    .raw    (raw),
    .fitted (fitted)
  );

  assign ce_d = hit && !romsel_n;
  assign oe_d = ce_d && !rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      rom_ce_n <= 1'b1;
      rom_oe_n <= 1'b1;
    end else begin
      rom_addr <= fitted;
      rom_ce_n <= !ce_d;
      rom_oe_n <= !oe_d;
    end
  end
endmodule

// File: rtl/rom_addr_mapper_chk.sv
module rom_addr_mapper_chk
  import rom_map_pkg::*;
#(
  parameter int ROM_LOG2 = 21
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        map_mode,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic              romsel_n,
  input logic [ROM_AW-1:0] rom_addr,
  input logic              rom_ce_n,
  input logic              rom_oe_n
);
  logic [31:0] addr_wide;
  assign addr_wide = 32'(rom_addr);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rom_ce_n && rom_oe_n && rom_addr == '0)); // R1

  AST_OE_WITHIN_CE: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_ce_n); // R8

  AST_SEL_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(romsel_n)) |-> rom_ce_n); // R7

  AST_ADDR_IN_SIZE: assert property (@(posedge clk) disable iff (rst)
    (addr_wide >> ROM_LOG2) == 32'd0); // R9

  AST_LO_A15_GATE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(map_mode) == 2'd0 && !$past(cpu_addr[15])) |-> rom_ce_n); // R3

  AST_LO_LOW_LINES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(map_mode) == 2'd0 && !rom_ce_n)
      |-> (rom_addr[14:0] == $past(cpu_addr[14:0]))); // R2

  AST_WRAM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(map_mode) == 2'd1 && $past(cpu_addr[23:17]) == 7'h3F)
      |-> rom_ce_n); // R4

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(map_mode) == 2'd3) |-> rom_ce_n); // R10
endmodule

bind rom_addr_mapper rom_addr_mapper_chk #(.ROM_LOG2(ROM_LOG2)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .map_mode (map_mode),
  .cpu_addr (cpu_addr),
  .romsel_n (romsel_n),
  .rom_addr (rom_addr),
  .rom_ce_n (rom_ce_n),
  .rom_oe_n (rom_oe_n)
);

// File: tb/rom_addr_mapper_test.sv
`timescale 1ns/1ps
module rom_addr_mapper_test;
  localparam int SZ = 21;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  map_mode = 2'd0;
  logic [23:0] cpu_addr = '0;
  logic        romsel_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [22:0] rom_addr;
  logic        rom_ce_n, rom_oe_n;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rom_addr_mapper #(.ROM_LOG2(SZ)) uut (
    .clk(clk), .rst(rst), .map_mode(map_mode), .cpu_addr(cpu_addr),
    .romsel_n(romsel_n), .rd_n(rd_n),
    .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n)
  );

  typedef struct packed {
    logic        ce;
    logic        oe;
    logic [22:0] addr;
  } exp_t;

  function automatic exp_t model(input int md, input logic [23:0] a,
                                 input logic sel_n, input logic rdn);
    exp_t e;
    int unsigned ra;
    logic [7:0] bank;
    logic hit;
    bank = a[23:16];
    hit = 1'b0;
    ra = 0;
    case (md)
      0: begin
        hit = (bank < 8'h80) && a[15];
        ra = 32'(a[14:0]) | (32'(a[21:16]) << 15) | (32'(a[23]) << 21);
      end
      1: begin
        hit = (bank >= 8'h40 && bank <= 8'h7D) || (bank >= 8'h80) ||
              (bank == 8'h00 && a[15:0] >= 16'hFFE0);
        ra = 32'(a[21:0]) | (32'(a[23]) << 22);
      end
      2: begin
        hit = a[15] && !(bank == 8'h7E || bank == 8'h7F);
        ra = 32'(a[14:0]) | (32'(a[22:16]) << 15) | (32'(a[23]) << 22);
      end
      default: hit = 1'b0;
    endcase
    ra = ra & ((32'd1 << SZ) - 1);
    e.ce = hit && !sel_n;
    e.oe = e.ce && !rdn;
    e.addr = ra[22:0];
    return e;
  endfunction

  task automatic check_outs(input string tag, input exp_t e);
    total++;
    if (rom_ce_n !== !e.ce || rom_oe_n !== !e.oe || (e.ce && rom_addr !== e.addr)) begin
      bad++;
      $display("FAIL %s: got ce_n=%b oe_n=%b addr=%h, expected ce_n=%b oe_n=%b addr=%h",
               tag, rom_ce_n, rom_oe_n, rom_addr, !e.ce, !e.oe, e.addr);
    end
  endtask

  task automatic apply(input string tag, input int md, input logic [23:0] a,
                       input logic sel_n, input logic rdn);
    @(negedge clk);
    map_mode = 2'(md);
    cpu_addr = a;
    romsel_n = sel_n;
    rd_n = rdn;
    @(negedge clk);
    check_outs(tag, model(md, a, sel_n, rdn));
  endtask

  task automatic expect_addr(input string tag, input logic [22:0] want);
    total++;
    if (rom_ce_n !== 1'b0 || rom_addr !== want) begin
      bad++;
      $display("FAIL %s: got ce_n=%b addr=%h, expected ce_n=0 addr=%h",
               tag, rom_ce_n, rom_addr, want);
    end
  endtask

  initial begin
    #(20.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [22:0] first;
    seed = 32'd1234;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    total++;
    if (rom_ce_n !== 1'b1 || rom_oe_n !== 1'b1 || rom_addr !== '0) begin
      bad++;
      $display("FAIL R1: got ce_n=%b oe_n=%b addr=%h, expected 1 1 0",
               rom_ce_n, rom_oe_n, rom_addr);
    end
    rst = 1'b0;

    // R2: low-half map literal
    apply("R2 lo map", 0, 24'h129ABC, 1'b0, 1'b0);
    expect_addr("R2 lo literal", 23'h091ABC);
    // R3: A15 low idle, A22 ignored
    apply("R3 lo a15 low", 0, 24'h121ABC, 1'b0, 1'b0);
    apply("R3 lo a22 set", 0, 24'h529ABC, 1'b0, 1'b0);
    expect_addr("R3 a22 ignored", 23'h091ABC);
    apply("R3 lo bank 80", 0, 24'h808000, 1'b0, 1'b0);
    // R4 / R5: linear high map
    apply("R4 hi bank 7E", 1, 24'h7E8000, 1'b0, 1'b0);
    apply("R4 hi bank 7D", 1, 24'h7D0010, 1'b0, 1'b0);
    apply("R4 hi bank 3F", 1, 24'h3FFFFF, 1'b0, 1'b0);
    apply("R5 hi vector", 1, 24'h00FFFC, 1'b0, 1'b0);
    expect_addr("R5 vector literal", 23'h00FFFC);
    apply("R5 hi vector low edge", 1, 24'h00FFE0, 1'b0, 1'b0);
    apply("R5 hi below vectors", 1, 24'h00FFDF, 1'b0, 1'b0);
    // R9: mirroring between banks C0 and E0 with a 2 MiB ROM
    apply("R9 hi C0", 1, 24'hC01234, 1'b0, 1'b0);
    first = rom_addr;
    apply("R9 hi E0", 1, 24'hE01234, 1'b0, 1'b0);
    expect_addr("R9 mirror", first);
    // R6: extended map
    apply("R6 ex bank 7D", 2, 24'h7D8000, 1'b0, 1'b0);
    apply("R6 ex bank 40", 2, 24'h408001, 1'b0, 1'b0);
    apply("R6 ex bank 7F", 2, 24'h7F8000, 1'b0, 1'b0);
    apply("R6 ex bank FF", 2, 24'hFFFFFF, 1'b0, 1'b0);
    // R7 / R8 / R10
    apply("R7 select high", 1, 24'hC00000, 1'b1, 1'b0);
    apply("R8 read high", 1, 24'hC00000, 1'b0, 1'b1);
    apply("R10 mode off", 3, 24'hC08000, 1'b0, 1'b0);

    for (int md = 0; md < 4; md++) begin
      for (int n = 0; n < 400; n++) begin
        logic [23:0] a;
        logic s, r;
        a = 24'($urandom);
        if (n % 5 == 0) a[23:16] = 8'h00;
        s = ($urandom % 5) == 0;
        r = ($urandom % 4) == 0;
        case (md)
          0: apply("R2 R3 R9 random lo", md, a, s, r);
          1: apply("R4 R5 R9 random hi", md, a, s, r);
          2: apply("R6 R9 random ex", md, a, s, r);
          default: apply("R10 R7 R8 random off", md, a, s, r);
        endcase
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule